// File: doc/BRIEF.md
# IrDA Return-to-Zero Pulse Codec

This block sits between a UART's serial bit lines and an infrared transceiver. On the transmit side it watches the UART's NRZ output. For every zero bit it drives one short pulse, and for every one bit it leaves the line at its inactive level. The pulse width follows one of two rules: a fixed share of the bit period, counted in the 16x sub-bit ticks that the UART already uses, or a fixed number of base-clock cycles. The transmit pulse polarity can be inverted. When infrared transmit is off, the UART line goes straight to the pin.

On the receive side, the pin is inverted if so configured and then synchronised. The block looks for rising edges of the active level. The first pulse after a quiet line locks a 16-tick bit window, with the pulse placed at sub-bit position 7. After that the window runs freely. At a programmable decision position in each window, the NRZ output is set to 0 if a pulse arrived since the previous decision, and to 1 otherwise. After a run of empty windows the decoder drops back to its quiet state.

Transmit states: `TX_PASS` (IR transmit off, pin follows the UART), `TX_WAIT` (line inactive, waiting for sub-bit 7 of a zero bit) and `TX_PULSE` (pulse driven). Transitions: any state goes to `TX_PASS` when IR transmit is disabled. `TX_PASS` goes to `TX_WAIT` when it is enabled. `TX_WAIT` goes to `TX_PULSE` at the tick that starts sub-bit 7 of a zero bit. `TX_PULSE` returns to `TX_WAIT` when the width is used up or when the UART line changes. Receive states: `RX_IDLE` (output held at 1, no window) and `RX_TRACK` (windows running). `RX_IDLE` goes to `RX_TRACK` on a pulse edge. `RX_TRACK` returns to `RX_IDLE` at the decision that closes the IDLE_WIN-th consecutive empty window.

Top module: `irda_rz_codec`

## Requirements
- R1: While `ir_tx_en` is 0, `ir_txd` equals `uart_txd` in the same cycle, whatever `tx_inv` and `tx_pw_base` are.
- R2: With `ir_tx_en`=1 and `tx_pw_base`=0, a zero bit on `uart_txd` produces one pulse that begins 7 ticks after the bit's first tick and lasts exactly 3 ticks. The sub-bit phase restarts at every change of `uart_txd` and wraps every 16 ticks.
- R3: With `tx_pw_base`=1, the pulse begins at the same point but lasts exactly BASE_PW clock cycles.
- R4: A one bit produces no pulse. With `tx_inv`=0 the inactive level of `ir_txd` is 0 and the pulse level is 1.
- R5: `tx_inv`=1 swaps the two levels of `ir_txd` in IR mode: the inactive level is 1 and a pulse is 0.
- R6: With `rx_inv`=0 a received pulse is a high level on `ir_rxd`. With `rx_inv`=1 it is a low level, and a high line is inactive.
- R7: The first pulse edge seen in the quiet state locks the window with that edge at sub-bit 7. At the tick that brings the window count to `rx_decide` (valid range 8 to 15), `uart_rxd` takes 0 if a pulse edge arrived since the previous decision and 1 otherwise, and holds that value for 16 ticks.
- R8: A pulse whose edge reaches the decoder after the decision point of its window is counted in the following window's decision.
- R9: After IDLE_WIN consecutive windows without a pulse, the decoder returns to the quiet state with `uart_rxd`=1. The next pulse locks a new window alignment.
- R10: After reset, `uart_rxd` is 1 and `ir_txd` follows `uart_txd` until IR transmit is enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | One-cycle strobe at 16 times the baud rate |
| uart_txd | input | 1 | NRZ serial output of the UART |
| ir_tx_en | input | 1 | 1: encode pulses, 0: pass `uart_txd` through |
| tx_pw_base | input | 1 | 0: pulse width 3 ticks, 1: BASE_PW clock cycles |
| tx_inv | input | 1 | Inverts the encoded pulse stream |
| ir_txd | output | 1 | Drive to the infrared transmitter |
| ir_rxd | input | 1 | Line from the infrared receiver (asynchronous) |
| rx_inv | input | 1 | Inverts the received line before detection |
| rx_decide | input | 4 | Window position at which a receive bit is judged |
| uart_rxd | output | 1 | Recovered NRZ stream for the UART receiver |

## Verification
Pass-through is combinational, so `ir_txd` is checked in the same cycle that `uart_txd` is driven. A transmitted pulse becomes visible in the cycle after the clock edge of the 7th tick of the bit. The bench counts cycles from the edge that presents the bit, expects the pulse over samples 28 to 28+W-1 for a 4-cycle tick spacing, and compares every cycle of every bit. On receive, a line change needs two synchroniser stages and one edge register before it is seen, and the output then changes at the edge of tick `rx_decide` of the window. The bench therefore samples `uart_rxd` 32 cycles after each decision edge, in the middle of the held value, and derives the expected bit from the pulse pattern, the decision position and the late-pulse rule.

// File: rtl/irda_rz_pkg.sv
package irda_rz_pkg;
    // Sub-bit phase handling (16 ticks per bit)
    localparam int unsigned PH_W          = 4;
    localparam logic [3:0]  TX_PULSE_PH   = 4'd7;
    localparam int unsigned TX_BAUD_TICKS = 3;
    localparam logic [3:0]  TX_PRE_PH     = TX_PULSE_PH - 4'd1;
    localparam logic [3:0]  TX_LAST_PH    = TX_PULSE_PH + 4'(TX_BAUD_TICKS - 1);
    localparam logic [3:0]  RX_LOCK_PH    = 4'd7;

    typedef enum logic [1:0] {
        TX_PASS  = 2'd0,
        TX_WAIT  = 2'd1,
        TX_PULSE = 2'd2
    } tx_state_e;

    typedef enum logic {
        RX_IDLE  = 1'b0,
        RX_TRACK = 1'b1
    } rx_state_e;
endpackage

// File: rtl/irda_rz_tx.sv
module irda_rz_tx
    import irda_rz_pkg::*;
#(
    parameter int unsigned BASE_PW = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick16,
    input  logic uart_txd,
    input  logic tx_en,
    input  logic pw_base,
    input  logic tx_inv,
    output logic ir_txd
);
    localparam int unsigned       PW_W    = (BASE_PW > 1) ? $clog2(BASE_PW) : 1;
    localparam logic [PW_W-1:0]   PW_LAST = PW_W'(BASE_PW - 1);

    tx_state_e        st, st_nx;
    logic [PH_W-1:0]  ph;
    logic [PW_W-1:0]  wcnt;
    logic             txd_q;
    logic             bit_edge;
    logic             pulse_go;
    logic             pulse_end;

    // A change on the UART line marks the start of a new bit
    assign bit_edge  = (uart_txd != txd_q);
    assign pulse_go  = tick16 && (ph == TX_PRE_PH) && !txd_q && !bit_edge;
    assign pulse_end = pw_base ? (wcnt == PW_LAST)
                               : (tick16 && (ph == TX_LAST_PH));

    always_comb begin
        st_nx = st;
        if (!tx_en) begin
            st_nx = TX_PASS;
        end else begin
            unique case (st)
                TX_PASS:  st_nx = TX_WAIT;
                TX_WAIT:  if (pulse_go) st_nx = TX_PULSE;
                TX_PULSE: if (bit_edge || pulse_end) st_nx = TX_WAIT;
                default:  st_nx = TX_PASS;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= TX_PASS;
        else        st <= st_nx;
    end

    // Sub-bit phase, bit value and base-clock width counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph    <= '0;
            txd_q <= 1'b1;
            wcnt  <= '0;
        end else begin
            txd_q <= uart_txd;
            if (bit_edge)    ph <= '0;
            else if (tick16) ph <= ph + 1'b1;
            if (st != TX_PULSE)     wcnt <= '0;
            else if (wcnt != PW_LAST) wcnt <= wcnt + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        if (!tx_en || (st == TX_PASS)) ir_txd = uart_txd;
        else                           ir_txd = (st == TX_PULSE) ^ tx_inv;
    end

    // R1: disabling returns the encoder to pass-through
    a_r1_pass_state: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> (st == TX_PASS));
    // R2: a pulse opens exactly at sub-bit 7
    a_r2_pulse_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st == TX_PULSE) |-> (ph == TX_PULSE_PH));
    // R2: in tick mode the pulse stays inside sub-bits 7..9
    a_r2_baud_window: assert property (@(posedge clk) disable iff (!rst_n)
        (st == TX_PULSE && !pw_base) |-> (ph >= TX_PULSE_PH && ph <= TX_LAST_PH));
    // R3: base-clock width counter never runs past its limit
    a_r3_base_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (st == TX_PULSE && pw_base) |-> (wcnt <= PW_LAST));
    // R4: no pulse is ever driven during a one bit
    a_r4_no_pulse_on_one: assert property (@(posedge clk) disable iff (!rst_n)
        (st == TX_PULSE) |-> !txd_q);
endmodule

// File: rtl/irda_rz_rx.sv
module irda_rz_rx
    import irda_rz_pkg::*;
#(
    parameter int unsigned IDLE_WIN = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick16,
    input  logic       ir_rxd,
    input  logic       rx_inv,
    input  logic [3:0] decide,
    output logic       uart_rxd
);
    localparam int unsigned     MW        = (IDLE_WIN > 2) ? $clog2(IDLE_WIN) : 1;
    localparam logic [MW-1:0]   MISS_LAST = MW'(IDLE_WIN - 1);

    rx_state_e        st, st_nx;
    logic             s1, s2, act_q;
    logic [PH_W-1:0]  cnt;
    logic             seen;
    logic [MW-1:0]    miss;
    logic             bit_q;
    logic             pulse_edge;
    logic             decide_now;
    logic             hit;
    logic             last_miss;

    assign pulse_edge = s2 && !act_q;
    assign decide_now = (st == RX_TRACK) && tick16 && ((cnt + 4'd1) == decide);
    assign hit        = seen || pulse_edge;
    assign last_miss  = (miss == MISS_LAST);

    always_comb begin
        st_nx = st;
        unique case (st)
            RX_IDLE:  if (pulse_edge) st_nx = RX_TRACK;
            RX_TRACK: if (decide_now && !hit && last_miss) st_nx = RX_IDLE;
            default:  st_nx = RX_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= RX_IDLE;
        else        st <= st_nx;
    end

    // Polarity, synchroniser, window counter and decision
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1    <= 1'b0;
            s2    <= 1'b0;
            act_q <= 1'b0;
            cnt   <= '0;
            seen  <= 1'b0;
            miss  <= '0;
            bit_q <= 1'b1;
        end else begin
            s1    <= ir_rxd ^ rx_inv;
            s2    <= s1;
            act_q <= s2;
            if (st == RX_IDLE) begin
                if (pulse_edge) begin
                    cnt  <= RX_LOCK_PH;
                    seen <= 1'b1;
                    miss <= '0;
                end
            end else begin
                if (tick16) cnt <= cnt + 1'b1;
                if (decide_now) begin
                    bit_q <= !hit;
                    seen  <= 1'b0;
                    miss  <= (hit || last_miss) ? '0 : miss + 1'b1;
                end else if (pulse_edge) begin
                    seen <= 1'b1;
                end
            end
        end
    end

    // Outputs
    always_comb uart_rxd = bit_q;

    // R7: locking places the pulse at sub-bit 7
    a_r7_lock_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (st == RX_IDLE && pulse_edge) |=> (st == RX_TRACK && cnt == RX_LOCK_PH));
    // R7: the output only moves at a decision point
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bit_q) |-> $past(decide_now));
    // R9: the quiet state always shows a one
    a_r9_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        (st == RX_IDLE) |-> uart_rxd);
    // R9: empty-window counter stays below its limit
    a_r9_miss_bound: assert property (@(posedge clk) disable iff (!rst_n)
        miss <= MISS_LAST);
endmodule

// File: rtl/irda_rz_codec.sv
module irda_rz_codec #(
    parameter int unsigned BASE_PW  = 6,
    parameter int unsigned IDLE_WIN = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick16,
    input  logic       uart_txd,
    input  logic       ir_tx_en,
    input  logic       tx_pw_base,
    input  logic       tx_inv,
    output logic       ir_txd,
    input  logic       ir_rxd,
    input  logic       rx_inv,
    input  logic [3:0] rx_decide,
    output logic       uart_rxd
);
    irda_rz_tx #(.BASE_PW(BASE_PW)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick16   (tick16),
        .uart_txd (uart_txd),
        .tx_en    (ir_tx_en),
        .pw_base  (tx_pw_base),
        .tx_inv   (tx_inv),
        .ir_txd   (ir_txd)
    );

    irda_rz_rx #(.IDLE_WIN(IDLE_WIN)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick16   (tick16),
        .ir_rxd   (ir_rxd),
        .rx_inv   (rx_inv),
        .decide   (rx_decide),
        .uart_rxd (uart_rxd)
    );
endmodule

// File: tb/irda_rz_codec_bench.sv
module irda_rz_codec_bench;
    localparam int BASE_PW  = 6;
    localparam int IDLE_WIN = 12;
    localparam int TDIV     = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       uart_txd = 1'b1;
    logic       ir_tx_en = 1'b0;
    logic       tx_pw_base = 1'b0;
    logic       tx_inv = 1'b0;
    logic       ir_txd;
    logic       ir_rxd = 1'b0;
    logic       rx_inv = 1'b0;
    logic [3:0] rx_decide = 4'd10;
    logic       uart_rxd;

    int checks = 0;
    int fails  = 0;
    int tphase = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    irda_rz_codec #(.BASE_PW(BASE_PW), .IDLE_WIN(IDLE_WIN)) u_irda_rz_codec (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .uart_txd(uart_txd),
        .ir_tx_en(ir_tx_en), .tx_pw_base(tx_pw_base), .tx_inv(tx_inv),
        .ir_txd(ir_txd), .ir_rxd(ir_rxd), .rx_inv(rx_inv),
        .rx_decide(rx_decide), .uart_rxd(uart_rxd)
    );

    task automatic step();
        @(negedge clk);
        tphase = (tphase + 1) % TDIV;
        tick16 = (tphase == 0);
    endtask

    task automatic chk(input string req, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    function automatic logic tx_exp(input logic b, input int n, input int w, input logic inv);
        return inv ^ ((b == 1'b0) && (n >= 7 * TDIV) && (n < 7 * TDIV + w));
    endfunction

    // Send one bit and compare ir_txd on every cycle of it
    task automatic send_tx_bit(input logic b, input int w, input logic inv,
                               input string req, input int idx);
        logic act_r, exp_r, e;
        bit   seen_bad;
        seen_bad = 1'b0;
        act_r = 1'b0;
        exp_r = 1'b0;
        while (tphase != 0) step();
        uart_txd = b;
        for (int n = 0; n < 16 * TDIV; n++) begin
            step();
            e = tx_exp(b, n, w, inv);
            if (!seen_bad && ir_txd !== e) begin
                seen_bad = 1'b1;
                act_r = ir_txd;
                exp_r = e;
            end
        end
        chk(req, act_r, exp_r, $sformatf("tx bit %0d value %b", idx, b));
    endtask

    task automatic tx_frame(input logic base, input logic inv, input string req);
        logic b;
        int w;
        w = base ? BASE_PW : 3 * TDIV;
        tx_pw_base = base;
        tx_inv = inv;
        ir_tx_en = 1'b1;
        uart_txd = 1'b1;
        repeat (8) step();
        chk("R4", ir_txd, inv, "idle level before frame");
        for (int k = 0; k < 10; k++) begin
            b = (k == 0) ? 1'b0 : 1'($urandom_range(0, 1));
            send_tx_bit(b, w, inv, req, k);
        end
        send_tx_bit(1'b0, w, inv, req, 10);
        send_tx_bit(1'b0, w, inv, req, 11);
        send_tx_bit(1'b1, w, inv, "R4", 12);
    endtask

    // Drive a pulse pattern into ir_rxd and check each decoded window
    task automatic rx_frame(input logic [15:0] pulses, input logic [15:0] late,
                            input int nb, input int d, input logic [15:0] expv,
                            input logic inv, input string req);
        int total, k, o, off, rel;
        logic act;
        rx_decide = 4'(d);
        while (tphase != 0) step();
        total = 64 * nb + 4 * d + 40;
        for (int n = 0; n < total; n++) begin
            k = n / 64;
            o = n % 64;
            off = late[k % 16] ? 44 : 28;
            act = (k < nb) && pulses[k % 16] && (o >= off) && (o < off + 12);
            ir_rxd = act ^ inv;
            step();
            rel = n - 4 * d - 32;
            if (rel >= 0 && rel % 64 == 0 && rel / 64 < nb)
                chk(req, uart_rxd, expv[rel / 64], $sformatf("rx window %0d", rel / 64));
        end
        ir_rxd = inv;
    endtask

    task automatic quiet();
        repeat (64 * (IDLE_WIN + 2) + 20) step();
    endtask

    initial begin
        logic [15:0] p;
        int d;
        void'($urandom(32'd7151));
        repeat (5) step();
        rst_n = 1'b1;
        step();
        // R10: reset state
        chk("R10", uart_rxd, 1'b1, "uart_rxd after reset");
        chk("R10", ir_txd, uart_txd, "ir_txd after reset");
        uart_txd = 1'b0;
        #1 chk("R10", ir_txd, 1'b0, "ir_txd follows low after reset");

        // R1: pass-through while disabled, with other controls varied
        for (int i = 0; i < 40; i++) begin
            step();
            uart_txd = 1'($urandom_range(0, 1));
            tx_inv = 1'($urandom_range(0, 1));
            tx_pw_base = 1'($urandom_range(0, 1));
            #1 chk("R1", ir_txd, uart_txd, "pass-through");
        end
        uart_txd = 1'b1;
        tx_inv = 1'b0;

        // R2/R4: tick-proportional width, R3: base-clock width, R5: inverted
        tx_frame(1'b0, 1'b0, "R2");
        tx_frame(1'b1, 1'b0, "R3");
        tx_frame(1'b0, 1'b1, "R5");
        tx_frame(1'b1, 1'b1, "R5");
        ir_tx_en = 1'b0;
        step();
        #1 chk("R1", ir_txd, uart_txd, "pass-through after disable");

        // R7: random frames, decision positions 8..15
        for (int f = 0; f < 3; f++) begin
            p = 16'($urandom_range(0, 16'hffff)) | 16'd1;
            d = $urandom_range(8, 15);
            rx_frame(p, 16'd0, 10, d, ~p, 1'b0, "R7");
            quiet();
        end
        // R6: inverted receive line
        rx_inv = 1'b1;
        ir_rxd = 1'b1;
        repeat (8) step();
        chk("R6", uart_rxd, 1'b1, "inverted idle line");
        p = 16'($urandom_range(0, 16'hffff)) | 16'd1;
        rx_frame(p, 16'd0, 10, 11, ~p, 1'b1, "R6");
        quiet();
        rx_inv = 1'b0;
        ir_rxd = 1'b0;
        repeat (8) step();

        // R8: late pulse in window 1, judged at two decision positions
        rx_frame(16'b0011, 16'b0010, 4, 10, 16'b1010, 1'b0, "R8");
        quiet();
        rx_frame(16'b0011, 16'b0010, 4, 12, 16'b1100, 1'b0, "R8");
        quiet();

        // R9: back in quiet state, relock on a single pulse
        chk("R9", uart_rxd, 1'b1, "quiet after empty windows");
        rx_frame(16'b0001, 16'd0, 3, 9, 16'b0110, 1'b0, "R9");
        quiet();
        chk("R9", uart_rxd, 1'b1, "quiet after relock frame");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule